// File: doc/BRIEF.md
# Locality Access Arbiter

This block holds the ownership state behind a per-locality access byte of a memory-mapped security-device interface. Up to five software localities, numbered 0 to 4, share one device. Each locality sees its own one-byte access register at offset 0x000 of its own 4 KB window. Address bits [14:12] select the window.

Through that byte a locality can ask for the device, give it back, clear its own "taken away" flag, or take the device at once from a lower-numbered locality. The arbiter keeps exactly zero or one owner. When the device is free it hands it to the highest-numbered waiting locality. It records, per locality, that ownership was taken by force. It also shows in every locality whether some other locality is waiting.

A level input reports whether a trusted OS has been established. It is reflected in the access byte and cannot be changed by writes. Reads are registered.

Access byte layout (bit: read meaning / write action):
- bit 7: always reads 1 / ignored.
- bit 6: reads 0 / ignored.
- bit 5: reads 1 if this locality owns the device / writing 1 gives the device up (owner only).
- bit 4: reads the seized flag / writing 1 clears it.
- bit 3: reads 0 / writing 1 forces takeover.
- bit 2: reads 1 if another locality is waiting / ignored.
- bit 1: reads 1 if this locality is waiting / writing 1 requests the device.
- bit 0: reads the establishment input / ignored.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality owns the device and no request or seized flag is held. A read of any locality then returns 0x80 with bit 0 equal to the establishment input.
- R2: Every read of a mapped access byte returns bit 7 = 1 and bit 0 = `est_flag_i`. Writing bits 7 and 0 changes nothing.
- R3: Writing 1 to bit 1 records a request for that locality, and it reads back in bit 1 until the request is granted. A request written by the current owner is ignored.
- R4: At most one locality reads bit 5 = 1 at any time, and that locality is the owner.
- R5: Bit 2 of locality L reads 1 exactly when a locality other than L holds a request.
- R6: The owner writing 1 to bit 5 clears ownership at that clock edge. A write of bit 5 by a non-owner is ignored.
- R7: While the device is free, at the next clock edge the highest-numbered requesting locality becomes the owner and its request is cleared. A request written at edge N on a free device is therefore granted at edge N+1.
- R8: Writing 1 to bit 3 makes the writer the owner at that edge when the device is free or owned by a lower-numbered locality, and clears the writer's request. If the owner has an equal or higher number, the write is ignored. A forced takeover wins over a grant in the same cycle.
- R9: The owner displaced by a forced takeover gets its seized flag (bit 4) set. The flag stays set until that locality writes 1 to bit 4.
- R10: Read data appears on `reg_rdata_o` the clock edge after the read strobe and holds until the next read. Reads of an unmapped address (window 5 to 7, or offset not 0x000) return 0x00, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| est_flag_i | input | 1 | 1 while no trusted OS is established |
| reg_addr_i | input | 15 | Byte address; [14:12] locality window, [11:0] offset |
| reg_wdata_i | input | 8 | Write data byte |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, one cycle per read |
| reg_rdata_o | output | 8 | Registered read data |

## Verification
A write updates ownership, requests and seized flags at the edge that samples its strobe. A free device is granted one edge later. A read strobe captures the state present just before its edge, and the captured value is visible one edge later. The bench drives every strobe for exactly one cycle from the falling edge and reads `reg_rdata_o` at the following falling edge. A read issued right after a write therefore shows the write's effect but not the grant that lands on the same edge. The bench uses this both to see a request before its grant and to see the empty device between a release and the following grant.

// File: rtl/loc_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared bit positions of the access byte and the decoded write command.
// Assumes one write per cycle; a write may carry several command bits at once.
package loc_arb_pkg;

    localparam int BIT_VALID   = 7;
    localparam int BIT_ACTIVE  = 5;
    localparam int BIT_SEIZED  = 4;
    localparam int BIT_SEIZE   = 3;
    localparam int BIT_PENDING = 2;
    localparam int BIT_REQ     = 1;
    localparam int BIT_EST     = 0;

    typedef struct packed {
        logic req;
        logic rel;
        logic seize;
        logic clr_seized;
    } acc_cmd_t;

    // Turn a written byte into the command bits it carries.
    function automatic acc_cmd_t decode_cmd(input logic [7:0] wb);
        acc_cmd_t c;
        c.req        = wb[BIT_REQ];
        c.rel        = wb[BIT_ACTIVE];
        c.seize      = wb[BIT_SEIZE];
        c.clr_seized = wb[BIT_SEIZED];
        return c;
    endfunction

endpackage

// File: rtl/loc_addr_decode.sv
`timescale 1ns/1ps
// Module: loc_addr_decode
// Splits a bus address into a locality number and a hit flag.
// A hit needs offset zero inside the window and a window number below NUM_LOC.
// Assumes ADDR_W > WIN_LSB and that the window field can hold NUM_LOC-1.
module loc_addr_decode #(
    parameter int NUM_LOC = 5,
    parameter int ADDR_W  = 15,
    parameter int WIN_LSB = 12,
    localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
    localparam int SEL_W  = ADDR_W - WIN_LSB
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [LOC_W-1:0]  loc_o
);

    logic [SEL_W-1:0] sel;

    // Pick the window field and check it against the mapped range.
    always_comb begin
        sel   = addr_i[ADDR_W-1:WIN_LSB];
        hit_o = (addr_i[WIN_LSB-1:0] == '0) && (int'(sel) < NUM_LOC);
        loc_o = LOC_W'(sel);
    end

endmodule

// File: rtl/loc_own_ctrl.sv
`timescale 1ns/1ps
// Module: loc_own_ctrl
// Holds the one-hot owner, the per-locality request bits and the seized flags.
// Per write: a forced takeover beats release; release beats the free-device grant;
// a grant picks the highest-numbered requester. Requests from the (new) owner drop.
// Assumes at most one write per cycle, already decoded to a locality and command.
module loc_own_ctrl
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [LOC_W-1:0]   wr_loc_i,
    input  acc_cmd_t           cmd_i,
    output logic [NUM_LOC-1:0] own_o,
    output logic [NUM_LOC-1:0] req_o,
    output logic [NUM_LOC-1:0] seized_o
);

    logic [NUM_LOC-1:0] own_q, req_q, sz_q;
    logic [NUM_LOC-1:0] own_n, req_n, sz_n;
    logic [NUM_LOC-1:0] wr_oh;
    logic [NUM_LOC-1:0] grant_pick;
    logic               do_seize, do_rel, do_grant;

    // One-hot of the writing locality, zero when there is no write.
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_wr_oh
        assign wr_oh[g] = wr_en_i && (wr_loc_i == LOC_W'(g));
    end

    // Highest-numbered set bit of a request vector, as a one-hot.
    function automatic logic [NUM_LOC-1:0] pick_hi(input logic [NUM_LOC-1:0] v);
        logic [NUM_LOC-1:0] p;
        p = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (v[i]) p = {{(NUM_LOC-1){1'b0}}, 1'b1} << i;
        end
        return p;
    endfunction

    // Decide which of the ownership events applies this cycle.
    always_comb begin
        grant_pick = pick_hi(req_q);
        do_seize   = (|wr_oh) && cmd_i.seize && (own_q < wr_oh);
        do_rel     = (|(wr_oh & own_q)) && cmd_i.rel && !cmd_i.seize;
        do_grant   = (own_q == '0) && (|req_q) && !do_seize;
    end

    // Next owner, requests and seized flags.
    always_comb begin
        own_n = own_q;
        req_n = req_q;
        sz_n  = sz_q;
        if (cmd_i.clr_seized) sz_n = sz_n & ~wr_oh;
        if (do_seize) begin
            sz_n  = sz_n | own_q;
            own_n = wr_oh;
            req_n = req_n & ~wr_oh;
        end else if (do_rel) begin
            own_n = '0;
        end else if (do_grant) begin
            own_n = grant_pick;
            req_n = req_n & ~grant_pick;
        end
        if (cmd_i.req) req_n = req_n | (wr_oh & ~own_n);
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
            req_q <= '0;
            sz_q  <= '0;
        end else begin
            own_q <= own_n;
            req_q <= req_n;
            sz_q  <= sz_n;
        end
    end

    assign own_o    = own_q;
    assign req_o    = req_q;
    assign seized_o = sz_q;

    // R4
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_q));

    // R8
    seize_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && cmd_i.seize && (own_q < wr_oh)) |=> (own_q == $past(wr_oh)));

    // R8
    seize_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && cmd_i.seize && (own_q != '0) && (own_q >= wr_oh))
            |=> $stable(own_q));

    // R9
    seized_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sz_q & ~$past(sz_q) & ~$past(own_q)) == '0));

    // R7
    grant_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_q == '0) && (|req_q) && !(wr_en_i && cmd_i.seize))
            |=> (|(own_q & $past(req_q))));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && cmd_i.rel && !cmd_i.seize && (|(own_q & wr_oh)))
            |=> (own_q == '0));

endmodule

// File: rtl/loc_read_port.sv
`timescale 1ns/1ps
// Module: loc_read_port
// Builds each locality's access byte from the shared state and registers
// the selected one on a read strobe. Unmapped reads return zero.
// Assumes the read data is held between reads.
module loc_read_port
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en_i,
    input  logic               hit_i,
    input  logic [LOC_W-1:0]   loc_i,
    input  logic [NUM_LOC-1:0] own_i,
    input  logic [NUM_LOC-1:0] req_i,
    input  logic [NUM_LOC-1:0] seized_i,
    input  logic               est_i,
    output logic [7:0]         rdata_o
);

    logic [7:0] acc_byte [NUM_LOC];
    logic [7:0] sel_byte;
    logic [7:0] rdata_q;

    // Assemble the access byte seen by each locality.
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_byte
        logic [NUM_LOC-1:0] others;
        assign others = req_i & ~({{(NUM_LOC-1){1'b0}}, 1'b1} << g);
        always_comb begin
            acc_byte[g]              = '0;
            acc_byte[g][BIT_VALID]   = 1'b1;
            acc_byte[g][BIT_ACTIVE]  = own_i[g];
            acc_byte[g][BIT_SEIZED]  = seized_i[g];
            acc_byte[g][BIT_PENDING] = |others;
            acc_byte[g][BIT_REQ]     = req_i[g];
            acc_byte[g][BIT_EST]     = est_i;
        end
    end

    // Select the addressed locality's byte, zero when unmapped.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (hit_i && (loc_i == LOC_W'(i))) sel_byte = acc_byte[i];
        end
    end

    // Capture on the read strobe and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= sel_byte;
    end

    assign rdata_o = rdata_q;

    // R2
    valid_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && hit_i) |=> (rdata_o[BIT_VALID] && (rdata_o[BIT_EST] == $past(est_i))));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit_i) |=> (rdata_o == 8'h00));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/locality_arbiter.sv
`timescale 1ns/1ps
// Module: locality_arbiter (top)
// Per-locality access byte: request, release, forced takeover by a higher locality,
// seized tracking and establishment flag. Connects decoder, state and read port.
// Assumes one-cycle read and write strobes, never both in the same cycle.
module locality_arbiter
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int ADDR_W  = 15,
    parameter int WIN_LSB = 12,
    localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              est_flag_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    output logic [7:0]        reg_rdata_o
);

    logic               hit;
    logic [LOC_W-1:0]   loc;
    acc_cmd_t           cmd;
    logic [NUM_LOC-1:0] own, req, seized;

    assign cmd = decode_cmd(reg_wdata_i);

    loc_addr_decode #(
        .NUM_LOC (NUM_LOC),
        .ADDR_W  (ADDR_W),
        .WIN_LSB (WIN_LSB)
    ) u_dec (
        .addr_i (reg_addr_i),
        .hit_o  (hit),
        .loc_o  (loc)
    );

    loc_own_ctrl #(
        .NUM_LOC (NUM_LOC)
    ) u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr_i && hit),
        .wr_loc_i (loc),
        .cmd_i    (cmd),
        .own_o    (own),
        .req_o    (req),
        .seized_o (seized)
    );

    loc_read_port #(
        .NUM_LOC (NUM_LOC)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (reg_rd_i),
        .hit_i    (hit),
        .loc_i    (loc),
        .own_i    (own),
        .req_i    (req),
        .seized_i (seized),
        .est_i    (est_flag_i),
        .rdata_o  (reg_rdata_o)
    );

endmodule

// File: tb/locality_arbiter_bench.sv
`timescale 1ns/1ps
module locality_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        est = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  rdata;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    locality_arbiter u_locality_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .est_flag_i  (est),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_rdata_o (rdata)
    );

    task automatic wr_acc(input int loc, input logic [7:0] v, input logic [11:0] off = 12'h000);
        addr = {3'(loc), off}; wdata = v; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int loc, input logic [7:0] exp,
                          input logic [11:0] off = 12'h000);
        addr = {3'(loc), off}; rd = 1'b1;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
        checks++;
        if (rdata !== exp) begin
            failures++;
            $display("FAIL %s loc=%0d actual=%02h expected=%02h", tag, loc, rdata, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 reset loc0", 0, 8'h81);
        rd_chk("R1 reset loc4", 4, 8'h81);
    endtask

    task automatic t_est();
        est = 1'b0;
        rd_chk("R2 est low", 2, 8'h80);
        wr_acc(2, 8'h81);
        rd_chk("R2 bits 7/0 write no effect", 2, 8'h80);
        est = 1'b1;
        rd_chk("R2 est high", 2, 8'h81);
    endtask

    task automatic t_request();
        wr_acc(1, 8'h02);
        rd_chk("R5 pending seen by loc0", 0, 8'h85);
        rd_chk("R7 loc1 granted", 1, 8'hA1);
        rd_chk("R5 no pending after grant", 0, 8'h81);
    endtask

    task automatic t_release_priority();
        wr_acc(0, 8'h02);
        wr_acc(3, 8'h02);
        rd_chk("R3 loc0 request held", 0, 8'h87);
        rd_chk("R5 owner sees pending", 1, 8'hA5);
        wr_acc(1, 8'h20);
        rd_chk("R6 free between release and grant", 0, 8'h87);
        rd_chk("R7 highest requester loc3 granted", 3, 8'hA5);
        rd_chk("R4 old owner inactive", 1, 8'h85);
        wr_acc(2, 8'h20);
        rd_chk("R6 non-owner release ignored", 3, 8'hA5);
    endtask

    task automatic t_seize();
        wr_acc(2, 8'h08);
        rd_chk("R8 lower seize ignored", 3, 8'hA5);
        rd_chk("R9 no seized flag on failed seize", 2, 8'h85);
        wr_acc(4, 8'h08);
        rd_chk("R8 loc4 takes over", 4, 8'hA5);
        rd_chk("R9 loc3 seized", 3, 8'h95);
        idle();
        rd_chk("R9 seized flag sticky", 3, 8'h95);
        wr_acc(3, 8'h10);
        rd_chk("R9 seized flag cleared", 3, 8'h85);
        wr_acc(4, 8'h08);
        rd_chk("R8 equal seize ignored", 4, 8'hA5);
        wr_acc(4, 8'h20);
        idle();
        rd_chk("R7 loc0 granted after release", 0, 8'hA1);
        wr_acc(2, 8'h0A);
        rd_chk("R8 seize with request", 2, 8'hA1);
        rd_chk("R9 loc0 seized", 0, 8'h91);
    endtask

    task automatic t_unmapped();
        rd_chk("R10 window 5 reads zero", 5, 8'h00);
        rd_chk("R10 offset 4 reads zero", 1, 8'h00, 12'h004);
        wr_acc(1, 8'h02, 12'h004);
        rd_chk("R10 unmapped write ignored", 1, 8'h81);
        wr_acc(6, 8'h08);
        rd_chk("R10 unmapped seize ignored", 2, 8'hA1);
        repeat (3) idle();
        checks++;
        if (rdata !== 8'hA1) begin
            failures++;
            $display("FAIL R10 read data not held actual=%02h expected=%02h", rdata, 8'hA1);
        end
    endtask

    task automatic t_owner_request();
        wr_acc(2, 8'h02);
        rd_chk("R3 owner request ignored", 2, 8'hA1);
        rd_chk("R5 no pending from owner", 0, 8'h91);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_est();
        t_request();
        t_release_priority();
        t_seize();
        t_unmapped();
        t_owner_request();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule